// File: doc/BRIEF.md
# Auto-Precharge Command Expander

This block sits in a DRAM command path and turns a time-stamped stream of memory commands into an equivalent stream with no combined column-plus-precharge operations. Each read or write that asks for an automatic precharge leaves the block as a plain read or write. For each one, the block also creates an explicit precharge to the same bank with its own time stamp. Those generated precharges wait in a small side queue. They are merged back into the main stream so that the output stays ordered by time stamp.

Commands enter and leave through valid/ready ports that use the same three fields: a 3-bit command code, a bank number and a cycle stamp. Three static configuration inputs set the timing used for the generated precharges: the read offset, the write offset and the minimum row-active time. A flush input empties the side queue once no normal command is left.

The block does not check DRAM timing legality and does no power accounting. It only rewrites and reorders commands. Command codes are NOP=0, ACT=1, RD=2, WR=3, RDA=4 (read with auto-precharge), WRA=5 (write with auto-precharge), PRE=6 and PREA=7 (precharge all).

Top module: `apx_expander`

## Requirements
- R1: Each accepted ACT (code 1) records its stamp as the activation time of its bank; activation times are 0 after reset. A later generated precharge to that bank is never stamped earlier than that activation time plus `cfg_tras`.
- R2: An RDA (code 4) leaves as RD (code 2), and a WRA (code 5) leaves as WR (code 3), with the same bank and stamp. Codes 4 and 5 never appear at the output.
- R3: Each RDA or WRA queues one PRE (code 6) to the same bank. Its stamp is the larger of two values: the command stamp plus `cfg_rd_ofs` (RDA) or `cfg_wr_ofs` (WRA), and the bank activation time plus `cfg_tras`.
- R4: While the side queue holds entries, a waiting normal command is emitted before the queue head only if its stamp is strictly smaller than the head's stamp. Otherwise the head is emitted first.
- R5: If the first command after reset has a stamp greater than 1, a single PREA (code 7) with bank 0 and stamp 0 is emitted before it. Otherwise no PREA is inserted.
- R6: With the side queue empty, commands other than RDA and WRA pass through unchanged and in input order.
- R7: The side queue holds `QDEPTH` (8) entries. While it is full, `in_ready` is low and the queue head is emitted even if no normal command is waiting.
- R8: While `flush` is high and no normal command is waiting, the queued precharges are emitted in the order they were queued, until the queue is empty.
- R9: While `out_valid` is high and `out_ready` is low, with `flush` low, the output fields hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd_ofs | input | OFS_W | Precharge offset added to an RDA stamp |
| cfg_wr_ofs | input | OFS_W | Precharge offset added to a WRA stamp |
| cfg_tras | input | OFS_W | Minimum activation-to-precharge distance |
| flush | input | 1 | Drain queued precharges when no normal command waits |
| in_valid | input | 1 | Input command valid |
| in_ready | output | 1 | Input command accepted this cycle when high with valid |
| in_type | input | 3 | Input command code |
| in_bank | input | BANK_W | Input bank number |
| in_stamp | input | STAMP_W | Input cycle stamp |
| out_valid | output | 1 | Output command valid |
| out_ready | input | 1 | Downstream accepts the output command |
| out_type | output | 3 | Output command code |
| out_bank | output | BANK_W | Output bank number |
| out_stamp | output | STAMP_W | Output cycle stamp |

## Verification
Two things can compete in the same cycle: emitting a waiting normal command and emitting the head of the precharge queue. This happens most sharply when both carry the same stamp, and also when an RDA or WRA push would fill the queue just as the next command tries to enter. The sweeps use stamp increments that include zero, so equal stamps and a full queue come up often, and they stall the output port on an irregular pattern. The bench runs an in-order model in which equal stamps favour the queue. It compares every emitted command, with its code, bank and stamp, against that model.

// File: rtl/apx_pkg.sv
package apx_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_RDA  = 3'd4,
    CMD_WRA  = 3'd5,
    CMD_PRE  = 3'd6,
    CMD_PREA = 3'd7
  } cmd_e;
endpackage

// File: rtl/apx_act_table.sv
module apx_act_table #(
  parameter int NBANK   = 4,
  parameter int BANK_W  = 2,
  parameter int STAMP_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [BANK_W-1:0]  wr_bank,
  input  logic [STAMP_W-1:0] wr_stamp,
  input  logic [BANK_W-1:0]  rd_bank,
  output logic [STAMP_W-1:0] rd_stamp
);
  logic [STAMP_W-1:0] act_q [NBANK];

  // one register per bank, written only when its bank is named
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic hit_en;
    assign hit_en = wr_en && (wr_bank == BANK_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      act_q[g] <= '0;
      else if (hit_en) act_q[g] <= wr_stamp;
    end
  end

  assign rd_stamp = act_q[rd_bank];
endmodule

// File: rtl/apx_pre_time.sv
module apx_pre_time #(
  parameter int STAMP_W = 16,
  parameter int OFS_W   = 8
) (
  input  logic [STAMP_W-1:0] cmd_stamp,
  input  logic               is_write,
  input  logic [STAMP_W-1:0] act_stamp,
  input  logic [OFS_W-1:0]   rd_ofs,
  input  logic [OFS_W-1:0]   wr_ofs,
  input  logic [OFS_W-1:0]   tras,
  output logic [STAMP_W-1:0] pre_stamp
);
  logic [OFS_W-1:0]   ofs_sel;
  logic [STAMP_W-1:0] by_cmd;
  logic [STAMP_W-1:0] by_act;

  always_comb begin
    ofs_sel   = is_write ? wr_ofs : rd_ofs;
    by_cmd    = cmd_stamp + {{(STAMP_W-OFS_W){1'b0}}, ofs_sel};
    by_act    = act_stamp + {{(STAMP_W-OFS_W){1'b0}}, tras};
    pre_stamp = (by_act > by_cmd) ? by_act : by_cmd;
  end
endmodule

// File: rtl/apx_pre_fifo.sv
module apx_pre_fifo #(
  parameter int DEPTH   = 8,
  parameter int BANK_W  = 2,
  parameter int STAMP_W = 16,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [BANK_W-1:0]  push_bank,
  input  logic [STAMP_W-1:0] push_stamp,
  input  logic               pop,
  output logic [BANK_W-1:0]  head_bank,
  output logic [STAMP_W-1:0] head_stamp,
  output logic [CNT_W-1:0]   count,
  output logic               empty,
  output logic               full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  logic [BANK_W-1:0]  bank_q  [DEPTH];
  logic [STAMP_W-1:0] stamp_q [DEPTH];
  logic [PTR_W-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  always_ff @(posedge clk) begin
    if (push) begin
      bank_q[wr_q]  <= push_bank;
      stamp_q[wr_q] <= push_stamp;
    end
  end

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) begin
      wr_d  = (wr_q == LAST_P) ? '0 : wr_q + 1'b1;
      cnt_d = cnt_d + 1'b1;
    end
    if (pop) begin
      rd_d  = (rd_q == LAST_P) ? '0 : rd_q + 1'b1;
      cnt_d = cnt_d - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  assign head_bank  = bank_q[rd_q];
  assign head_stamp = stamp_q[rd_q];
  assign count      = cnt_q;
  assign empty      = (cnt_q == '0);
  assign full       = (cnt_q == FULL_C);
endmodule

// File: rtl/apx_expander.sv
module apx_expander #(
  parameter int NBANK   = 4,
  parameter int STAMP_W = 16,
  parameter int OFS_W   = 8,
  parameter int QDEPTH  = 8,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OFS_W-1:0]   cfg_rd_ofs,
  input  logic [OFS_W-1:0]   cfg_wr_ofs,
  input  logic [OFS_W-1:0]   cfg_tras,
  input  logic               flush,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2:0]         in_type,
  input  logic [BANK_W-1:0]  in_bank,
  input  logic [STAMP_W-1:0] in_stamp,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [2:0]         out_type,
  output logic [BANK_W-1:0]  out_bank,
  output logic [STAMP_W-1:0] out_stamp
);
  import apx_pkg::*;

  localparam int CNT_W = $clog2(QDEPTH + 1);
  localparam logic [CNT_W:0]     DEPTH_L = (CNT_W + 1)'(QDEPTH);
  localparam logic [STAMP_W-1:0] ONE_S   = STAMP_W'(1);

  // holding slot for the one normal command waiting to leave
  logic               cur_v, cur_v_d, started, started_d;
  cmd_e               cur_cmd;
  logic [BANK_W-1:0]  cur_bank;
  logic [STAMP_W-1:0] cur_stamp, cur_pre;

  cmd_e               in_cmd;
  logic               load, cur_auto, cur_ok, sel_prea, head_first;
  logic               fire, cur_fire, q_push, q_pop;
  logic [CNT_W:0]     room_sum;
  logic [STAMP_W-1:0] act_rd, pre_calc;
  logic [BANK_W-1:0]  q_head_bank;
  logic [STAMP_W-1:0] q_head_stamp;
  logic [CNT_W-1:0]   q_cnt;
  logic               q_empty, q_full;

  assign in_cmd = cmd_e'(in_type);

  apx_act_table #(.NBANK(NBANK), .BANK_W(BANK_W), .STAMP_W(STAMP_W)) act_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(load && (in_cmd == CMD_ACT)), .wr_bank(in_bank), .wr_stamp(in_stamp),
    .rd_bank(in_bank), .rd_stamp(act_rd)
  );

  apx_pre_time #(.STAMP_W(STAMP_W), .OFS_W(OFS_W)) time_i (
    .cmd_stamp(in_stamp), .is_write(in_cmd == CMD_WRA), .act_stamp(act_rd),
    .rd_ofs(cfg_rd_ofs), .wr_ofs(cfg_wr_ofs), .tras(cfg_tras),
    .pre_stamp(pre_calc)
  );

  apx_pre_fifo #(.DEPTH(QDEPTH), .BANK_W(BANK_W), .STAMP_W(STAMP_W), .CNT_W(CNT_W)) q_i (
    .clk(clk), .rst_n(rst_n),
    .push(q_push), .push_bank(cur_bank), .push_stamp(cur_pre),
    .pop(q_pop), .head_bank(q_head_bank), .head_stamp(q_head_stamp),
    .count(q_cnt), .empty(q_empty), .full(q_full)
  );

  // output selection: leading PREA, then queue head vs waiting command
  always_comb begin
    cur_auto   = (cur_cmd == CMD_RDA) || (cur_cmd == CMD_WRA);
    cur_ok     = cur_v && !(cur_auto && q_full);
    sel_prea   = cur_v && !started && (cur_stamp > ONE_S);
    head_first = !sel_prea && !q_empty &&
                 (cur_v ? (cur_stamp >= q_head_stamp) : (flush || q_full));
    out_valid  = sel_prea || head_first || cur_ok;
    if (sel_prea) begin
      out_type  = CMD_PREA;
      out_bank  = '0;
      out_stamp = '0;
    end else if (head_first) begin
      out_type  = CMD_PRE;
      out_bank  = q_head_bank;
      out_stamp = q_head_stamp;
    end else begin
      case (cur_cmd)
        CMD_RDA: out_type = CMD_RD;
        CMD_WRA: out_type = CMD_WR;
        default: out_type = cur_cmd;
      endcase
      out_bank  = cur_bank;
      out_stamp = cur_stamp;
    end
  end

  always_comb begin
    fire      = out_valid && out_ready;
    cur_fire  = fire && !sel_prea && !head_first;
    q_pop     = fire && head_first;
    q_push    = cur_fire && cur_auto;
    room_sum  = {1'b0, q_cnt} + {{CNT_W{1'b0}}, q_push};
    in_ready  = (!cur_v || cur_fire) && (room_sum < DEPTH_L);
    load      = in_valid && in_ready;
    cur_v_d   = load ? 1'b1 : (cur_fire ? 1'b0 : cur_v);
    started_d = started || fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_v   <= 1'b0;
      started <= 1'b0;
    end else begin
      cur_v   <= cur_v_d;
      started <= started_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      cur_cmd   <= in_cmd;
      cur_bank  <= in_bank;
      cur_stamp <= in_stamp;
      cur_pre   <= pre_calc;
    end
  end
endmodule

// File: rtl/apx_expander_chk.sv
module apx_expander_chk #(
  parameter int BANK_W  = 2,
  parameter int STAMP_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [2:0]         out_type,
  input logic [BANK_W-1:0]  out_bank,
  input logic [STAMP_W-1:0] out_stamp,
  input logic               q_full
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_type) &&
    $stable(out_bank) && $stable(out_stamp)); // R9

  AST_NO_AUTO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_type != 3'd4) && (out_type != 3'd5)); // R2

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !in_ready); // R7

  AST_FULL_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> out_valid && (out_type == 3'd6)); // R7

  AST_PREA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_type == 3'd7) |-> (out_stamp == '0) && (out_bank == '0)); // R5
endmodule

bind apx_expander apx_expander_chk #(.BANK_W(BANK_W), .STAMP_W(STAMP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
  .out_bank(out_bank), .out_stamp(out_stamp), .q_full(q_full)
);

// File: tb/apx_expander_tb_top.sv
module apx_expander_tb_top;
  localparam int CLK_P   = 10;
  localparam int NBANK   = 4;
  localparam int BANK_W  = 2;
  localparam int STAMP_W = 16;
  localparam int OFS_W   = 8;
  localparam int QD      = 8;

  logic clk, rst_n, flush, in_valid, in_ready, out_valid, out_ready;
  logic [OFS_W-1:0] cfg_rd_ofs, cfg_wr_ofs, cfg_tras;
  logic [2:0] in_type, out_type;
  logic [BANK_W-1:0] in_bank, out_bank;
  logic [STAMP_W-1:0] in_stamp, out_stamp;

  int checks = 0;
  int errors = 0;

  apx_expander #(.NBANK(NBANK), .STAMP_W(STAMP_W), .OFS_W(OFS_W), .QDEPTH(QD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_rd_ofs(cfg_rd_ofs), .cfg_wr_ofs(cfg_wr_ofs),
    .cfg_tras(cfg_tras), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_type(in_type), .in_bank(in_bank), .in_stamp(in_stamp),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
    .out_bank(out_bank), .out_stamp(out_stamp)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  // stimulus and expected stream
  int it [64]; int ib [64]; int is [64]; int n_in;
  int et [64]; int eb [64]; int es [64]; string eg [64]; int n_exp;
  // model side queue
  int qb [QD]; int qs [QD]; string qg [QD]; int q_head, q_cnt;
  int act_m [NBANK];

  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic add_exp(input int t, input int b, input int s, input string g);
    et[n_exp] = t; eb[n_exp] = b; es[n_exp] = s; eg[n_exp] = g;
    n_exp++;
  endtask

  task automatic model_pop(input string g_override);
    add_exp(6, qb[q_head], qs[q_head], (g_override == "") ? qg[q_head] : g_override);
    q_head = (q_head + 1) % QD;
    q_cnt--;
  endtask

  task automatic build(input int sess);
    int stamp;
    n_in = (sess == 6) ? 24 : 20;
    n_exp = 0; q_head = 0; q_cnt = 0;
    for (int k = 0; k < NBANK; k++) act_m[k] = 0;
    stamp = sess;
    for (int i = 0; i < n_in; i++) begin
      if (i > 0) stamp = stamp + ((i * 3 + sess) % 4);
      it[i] = (sess == 6) ? (4 + (i % 2)) : ((i * 5 + sess) % 7);
      ib[i] = (i * 3 + sess) % NBANK;
      is[i] = stamp;
    end
    for (int i = 0; i < n_in; i++) begin
      int ofs, by_c, by_a;
      if (i == 0 && is[0] > 1) add_exp(7, 0, 0, "R5");
      if (q_cnt == QD) model_pop("R7");
      while (q_cnt > 0 && qs[q_head] <= is[i]) model_pop("");
      if (it[i] == 4 || it[i] == 5)
        add_exp(it[i] - 2, ib[i], is[i], "R2");
      else
        add_exp(it[i], ib[i], is[i], (q_cnt == 0) ? "R6" : "R4");
      if (it[i] == 1) act_m[ib[i]] = is[i];
      if (it[i] == 4 || it[i] == 5) begin
        ofs  = (it[i] == 5) ? int'(cfg_wr_ofs) : int'(cfg_rd_ofs);
        by_c = is[i] + ofs;
        by_a = act_m[ib[i]] + int'(cfg_tras);
        qb[(q_head + q_cnt) % QD] = ib[i];
        qs[(q_head + q_cnt) % QD] = (by_a > by_c) ? by_a : by_c;
        qg[(q_head + q_cnt) % QD] = (by_a > by_c) ? "R1" : "R3";
        q_cnt++;
      end
    end
    while (q_cnt > 0) model_pop((q_cnt == QD) ? "R7" : "R8");
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; flush = 1'b0; out_ready = 1'b0;
    in_type = '0; in_bank = '0; in_stamp = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid && in_ready, "reset out_valid/in_ready R6", {out_valid, in_ready}, 1);
    @(negedge clk);
  endtask

  task automatic run_session(input int sess);
    int idx, oidx, cyc;
    bit hold_v;
    logic [2:0] h_t; logic [BANK_W-1:0] h_b; logic [STAMP_W-1:0] h_s;
    cfg_rd_ofs = (sess == 6) ? 8'd200 : OFS_W'(2 + sess);
    cfg_wr_ofs = (sess == 6) ? 8'd200 : OFS_W'(7 - sess);
    cfg_tras   = OFS_W'(3 * sess + 2);
    do_reset();
    build(sess);
    idx = 0; oidx = 0; cyc = 0; hold_v = 1'b0;
    while (!(idx == n_in && oidx == n_exp) && cyc < 5000) begin
      in_valid  = (idx < n_in);
      in_type   = (idx < n_in) ? 3'(it[idx]) : 3'd0;
      in_bank   = (idx < n_in) ? BANK_W'(ib[idx]) : '0;
      in_stamp  = (idx < n_in) ? STAMP_W'(is[idx]) : '0;
      flush     = (idx >= n_in);
      out_ready = ((cyc * 3 + sess) % 5) != 0;
      #1;
      if (hold_v)
        chk(out_valid && out_type == h_t && out_bank == h_b && out_stamp == h_s,
            "R9 stalled output held", int'(out_stamp), int'(h_s));
      hold_v = out_valid && !out_ready && !flush;
      h_t = out_type; h_b = out_bank; h_s = out_stamp;
      if (out_valid && out_ready) begin
        if (oidx < n_exp)
          chk(int'(out_type) == et[oidx] && int'(out_bank) == eb[oidx] &&
              int'(out_stamp) == es[oidx], eg[oidx],
              int'(out_type) * 100000 + int'(out_bank) * 10000 + int'(out_stamp),
              et[oidx] * 100000 + eb[oidx] * 10000 + es[oidx]);
        else
          chk(1'b0, "R8 extra output", int'(out_type), -1);
        oidx++;
      end
      if (in_valid && in_ready) idx++;
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 5000, "R7 session progress", cyc, 5000);
    in_valid = 1'b0; flush = 1'b1; out_ready = 1'b1;
    repeat (3) begin
      #1;
      chk(!out_valid, "R8 queue empty after flush", int'(out_valid), 0);
      @(negedge clk);
    end
    flush = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cfg_rd_ofs = '0; cfg_wr_ofs = '0; cfg_tras = '0;
    for (int s = 0; s < 7; s++) run_session(s);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule